// File: doc/BRIEF.md
# Iterative SM4 Block Cipher Core

This core runs the SM4 block cipher on one 128-bit block, spending one clock per round over 32 rounds. The block is split into four 32-bit words, with word 0 taken from the most significant end and each word read big-endian. Every round XORs the three newer words with that round's 32-bit key and passes the result through four byte-wide S-boxes. It then applies a linear mix of rotations by 2, 10, 18 and 24 bits and XORs the mixed value into the oldest word. The word window then slides by one. After the last round the final four words are emitted in reverse order.

Round keys come from outside through a read port. The core presents a 5-bit key index and expects the matching 32-bit key word back in the same cycle, as from a register file or an asynchronously read key RAM. Encryption and decryption share one datapath. A mode bit, latched at start, only reverses the order in which key indices are presented. Key expansion is outside the core.

Control is a three-state machine. `ST_IDLE` moves to `ST_ROUND` on an accepted start (the load transition). `ST_ROUND` stays in `ST_ROUND` while the round counter is below 31 (the step transition), and moves to `ST_DONE` after round 31 (the finish transition). `ST_DONE` always returns to `ST_IDLE` after one cycle (the release transition).

Top module: `sm4_iter_core`

## Requirements
- R1: While reset is asserted and after it is released, `done` is 0 and `dout` is all zeros until the first operation completes.
- R2: A `start` that is high at a rising edge while the core is idle is accepted: `din` and `decrypt` are captured at that edge, and `done` is high in the cycle after the 32nd following rising edge.
- R3: In the cycle of round r (r = 0 to 31, with round 0 being the cycle right after the accepting edge), `key_idx` equals r for encryption (`decrypt`=0) and 31 − r for decryption (`decrypt`=1). `key_word` is used in that same cycle.
- R4: Each round forms T = X1 ^ X2 ^ X3 ^ key, substitutes each byte of T through the SM4 S-box to get B, and produces X0 ^ B ^ rol(B,2) ^ rol(B,10) ^ rol(B,18) ^ rol(B,24). That value becomes the newest word while X1..X3 shift down. With key and plaintext both 0123456789ABCDEFFEDCBA9876543210, encryption gives 681EDF34D206965E86B3E94F536E4246.
- R5: `din[127:96]` is X0 and `din[31:0]` is X3. `dout` is {X35, X34, X33, X32}, with X35 in `dout[127:96]`.
- R6: Running the core with `decrypt`=1 on a ciphertext, using the same key store, returns the original plaintext.
- R7: `done` is high for exactly one cycle per accepted start and at no other time.
- R8: `dout` changes only in the cycle in which `done` rises, and otherwise holds its value through later idle periods and later starts.
- R9: A `start` seen during the 32 round cycles or during the `done` cycle is ignored. The running operation keeps its timing and result, and no extra `done` appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation; honoured only when idle |
| decrypt | input | 1 | 1 selects decryption (reverse key order), 0 encryption; sampled with start |
| din | input | 128 | Input block, X0 in the top word |
| key_idx | output | 5 | Index of the round key needed in the current round |
| key_word | input | 32 | Round key selected by key_idx, same cycle |
| dout | output | 128 | Result block, held until the next completion |
| done | output | 1 | One-cycle pulse when dout has been updated |

## Verification
The assertions assume that a `start` is a synchronous level sampled at rising edges. They also assume that `decrypt` and `din` are meaningful only at an accepting edge, and that `key_word` settles within the cycle in which `key_idx` is shown. The bench drives all inputs on falling edges and returns key words from a combinational array indexed by `key_idx`, so both assumptions hold. The checker keeps its own count of cycles since an accepted start, so the relation between the latency window and the ignored starts does not depend on the design's state register.

// File: rtl/sm4_pkg.sv
package sm4_pkg;

    localparam int NUM_ROUNDS = 32;
    localparam int WORD_W     = 32;
    localparam int NUM_WORDS  = 4;
    localparam int BLOCK_W    = NUM_WORDS * WORD_W;
    localparam int RND_W      = $clog2(NUM_ROUNDS);
    localparam int BYTE_W     = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ROUND = 2'd1,
        ST_DONE  = 2'd2
    } core_state_e;

    // Affine map into the inversion field: column i is the image of input bit i.
    localparam logic [63:0] INTO_COLS = {8'h12, 8'h09, 8'h49, 8'hA2,
                                         8'h56, 8'hE5, 8'h73, 8'h06};
    localparam logic [7:0]  INTO_K    = 8'h01;
    // Affine map back out of the inversion field.
    localparam logic [63:0] OUTOF_COLS = {8'hBF, 8'hDD, 8'hAF, 8'hDC,
                                          8'hB6, 8'hFA, 8'hA9, 8'h3C};
    localparam logic [7:0]  OUTOF_K    = 8'h34;
    // Constant of the affine step that follows inversion.
    localparam logic [7:0]  MID_K      = 8'h63;
    // Reduction remainder of the inversion field polynomial.
    localparam logic [7:0]  FIELD_RED  = 8'h1B;

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? FIELD_RED : 8'h00);
        end
        return acc;
    endfunction

    // Multiplicative inverse as x^254; zero maps to zero.
    function automatic logic [7:0] gf_inv(input logic [7:0] x);
        logic [7:0] p2, p3, p6, p12, p15, p30, p60, p120, p240, p252;
        p2   = gf_mul(x, x);
        p3   = gf_mul(p2, x);
        p6   = gf_mul(p3, p3);
        p12  = gf_mul(p6, p6);
        p15  = gf_mul(p12, p3);
        p30  = gf_mul(p15, p15);
        p60  = gf_mul(p30, p30);
        p120 = gf_mul(p60, p60);
        p240 = gf_mul(p120, p120);
        p252 = gf_mul(p240, p12);
        return gf_mul(p252, p2);
    endfunction

    function automatic logic [7:0] col_map(input logic [63:0] cols,
                                           input logic [7:0]  k,
                                           input logic [7:0]  x);
        logic [7:0] r;
        r = k;
        for (int i = 0; i < BYTE_W; i++) begin
            if (x[i]) r = r ^ cols[i*BYTE_W +: BYTE_W];
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
        return (x << n) | (x >> (BYTE_W - n));
    endfunction

    function automatic logic [7:0] mid_affine(input logic [7:0] x);
        return x ^ rotl8(x, 1) ^ rotl8(x, 2) ^ rotl8(x, 3) ^ rotl8(x, 4) ^ MID_K;
    endfunction

    function automatic logic [WORD_W-1:0] rotl32(input logic [WORD_W-1:0] w, input int n);
        return (w << n) | (w >> (WORD_W - n));
    endfunction

endpackage

// File: rtl/sm4_sbox.sv
module sm4_sbox
    import sm4_pkg::*;
(
    input  logic [BYTE_W-1:0] in_byte,
    output logic [BYTE_W-1:0] out_byte
);

    logic [BYTE_W-1:0] mapped_in;
    logic [BYTE_W-1:0] inverted;
    logic [BYTE_W-1:0] mixed;

    always_comb begin
        mapped_in = col_map(INTO_COLS, INTO_K, in_byte);
        inverted  = gf_inv(mapped_in);
        mixed     = mid_affine(inverted);
        out_byte  = col_map(OUTOF_COLS, OUTOF_K, mixed);
    end

endmodule

// File: rtl/sm4_round.sv
module sm4_round
    import sm4_pkg::*;
(
    input  logic [WORD_W-1:0] oldest,
    input  logic [WORD_W-1:0] w1,
    input  logic [WORD_W-1:0] w2,
    input  logic [WORD_W-1:0] w3,
    input  logic [WORD_W-1:0] rkey,
    output logic [WORD_W-1:0] fresh
);

    localparam int NBYTES = WORD_W / BYTE_W;

    logic [WORD_W-1:0] mix_in;
    logic [WORD_W-1:0] subst;

    assign mix_in = w1 ^ w2 ^ w3 ^ rkey;

    for (genvar g = 0; g < NBYTES; g++) begin : g_sbox
        sm4_sbox u_sbox (
            .in_byte (mix_in[g*BYTE_W +: BYTE_W]),
            .out_byte(subst[g*BYTE_W +: BYTE_W])
        );
    end

    always_comb begin
        fresh = oldest ^ subst
              ^ rotl32(subst, 2)
              ^ rotl32(subst, 10)
              ^ rotl32(subst, 18)
              ^ rotl32(subst, 24);
    end

endmodule

// File: rtl/sm4_ctrl.sv
module sm4_ctrl
    import sm4_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             load,
    output logic             step,
    output logic             last,
    output logic             fin,
    output logic [RND_W-1:0] rnd
);

    localparam logic [RND_W-1:0] LAST_RND = RND_W'(NUM_ROUNDS - 1);

    core_state_e state_q, state_d;
    logic [RND_W-1:0] rnd_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_ROUND;
            ST_ROUND: if (rnd_q == LAST_RND) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and round counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rnd_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE)
                rnd_q <= '0;
            else if (state_q == ST_ROUND && rnd_q != LAST_RND)
                rnd_q <= rnd_q + RND_W'(1);
        end
    end

    // outputs
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        last = 1'b0;
        fin  = 1'b0;
        unique case (state_q)
            ST_IDLE:  load = start;
            ST_ROUND: begin
                step = 1'b1;
                last = (rnd_q == LAST_RND);
            end
            ST_DONE:  fin = 1'b1;
            default:  ;
        endcase
    end

    assign rnd = rnd_q;

endmodule

// File: rtl/sm4_iter_core.sv
module sm4_iter_core
    import sm4_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               decrypt,
    input  logic [127:0]       din,
    output logic [4:0]         key_idx,
    input  logic [31:0]        key_word,
    output logic [127:0]       dout,
    output logic               done
);

    localparam logic [RND_W-1:0] LAST_RND = RND_W'(NUM_ROUNDS - 1);

    logic             load, step, last, fin;
    logic [RND_W-1:0] rnd;
    logic             dec_q;
    logic [WORD_W-1:0] win_q [NUM_WORDS];
    logic [WORD_W-1:0] fresh;
    logic [BLOCK_W-1:0] res_q;

    sm4_ctrl u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .load (load),
        .step (step),
        .last (last),
        .fin  (fin),
        .rnd  (rnd)
    );

    sm4_round u_round (
        .oldest(win_q[0]),
        .w1    (win_q[1]),
        .w2    (win_q[2]),
        .w3    (win_q[3]),
        .rkey  (key_word),
        .fresh (fresh)
    );

    // key order: ascending for encryption, descending for decryption
    assign key_idx = dec_q ? (LAST_RND - rnd) : rnd;

    // word window and mode register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= 1'b0;
            for (int i = 0; i < NUM_WORDS; i++) win_q[i] <= '0;
        end else if (load) begin
            dec_q <= decrypt;
            for (int i = 0; i < NUM_WORDS; i++)
                win_q[i] <= din[BLOCK_W-1-i*WORD_W -: WORD_W];
        end else if (step) begin
            for (int i = 0; i < NUM_WORDS-1; i++) win_q[i] <= win_q[i+1];
            win_q[NUM_WORDS-1] <= fresh;
        end
    end

    // result register: newest word at the top, oldest kept word at the bottom
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            res_q <= '0;
        else if (last)
            res_q <= {fresh, win_q[3], win_q[2], win_q[1]};
    end

    assign dout = res_q;
    assign done = fin;

endmodule

// File: rtl/sm4_core_chk.sv
module sm4_core_chk
    import sm4_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         decrypt,
    input logic [4:0]   key_idx,
    input logic [127:0] dout,
    input logic         done
);

    logic             active;
    logic [RND_W:0]   cnt;
    logic             dec_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            dec_c  <= 1'b0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                cnt    <= '0;
                dec_c  <= decrypt;
            end
        end else if (cnt == (RND_W+1)'(NUM_ROUNDS)) begin
            active <= 1'b0;
        end else begin
            cnt <= cnt + (RND_W+1)'(1);
        end
    end

    // R2: completion arrives exactly at the end of the round window
    a_r2_done_at_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt == (RND_W+1)'(NUM_ROUNDS)) |-> done);

    // R7 / R9: no completion outside that slot
    a_r7_done_only_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (active && cnt == (RND_W+1)'(NUM_ROUNDS)));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: result only moves with done
    a_r8_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> done);

    // R3: key order per mode
    a_r3_enc_key_order: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt < (RND_W+1)'(NUM_ROUNDS) && !dec_c) |-> key_idx == cnt[RND_W-1:0]);

    a_r3_dec_key_order: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt < (RND_W+1)'(NUM_ROUNDS) && dec_c)
            |-> key_idx == (RND_W'(NUM_ROUNDS - 1) - cnt[RND_W-1:0]));

endmodule

bind sm4_iter_core sm4_core_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .decrypt(decrypt),
    .key_idx(key_idx),
    .dout   (dout),
    .done   (done)
);

// File: tb/sim_sm4_iter_core.sv
module sim_sm4_iter_core;

    localparam int CLK_PERIOD = 10;
    localparam logic [127:0] VEC_KEY = 128'h0123456789ABCDEFFEDCBA9876543210;
    localparam logic [127:0] VEC_PT  = 128'h0123456789ABCDEFFEDCBA9876543210;
    localparam logic [127:0] VEC_CT  = 128'h681EDF34D206965E86B3E94F536E4246;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         decrypt = 1'b0;
    logic [127:0] din = '0;
    logic [4:0]   key_idx;
    logic [31:0]  key_word;
    logic [127:0] dout;
    logic         done;

    int checks = 0;
    int bad = 0;
    bit finished = 0;
    bit run_cmp = 0;

    logic [7:0]  sb [256];
    logic [31:0] rk_mem [32];

    sm4_iter_core u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt),
        .din(din), .key_idx(key_idx), .key_word(key_word),
        .dout(dout), .done(done)
    );

    assign key_word = rk_mem[key_idx];

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- reference helpers ----------------
    function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] prod;
        prod = '0;
        for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (prod[i]) prod = prod ^ (16'h011B << (i - 8));
        return prod[7:0];
    endfunction

    function automatic logic [7:0] b_inv(input logic [7:0] a);
        logic [7:0] r;
        r = 8'h00;
        for (int y = 1; y < 256; y++) if (b_mul(a, 8'(y)) == 8'h01) r = 8'(y);
        return r;
    endfunction

    function automatic logic [7:0] b_lin(input logic [7:0] x, input logic [7:0] k,
                                         input logic [7:0] c0, input logic [7:0] c1,
                                         input logic [7:0] c2, input logic [7:0] c3,
                                         input logic [7:0] c4, input logic [7:0] c5,
                                         input logic [7:0] c6, input logic [7:0] c7);
        logic [7:0] r;
        r = k;
        if (x[7]) r ^= c7; if (x[6]) r ^= c6; if (x[5]) r ^= c5; if (x[4]) r ^= c4;
        if (x[3]) r ^= c3; if (x[2]) r ^= c2; if (x[1]) r ^= c1; if (x[0]) r ^= c0;
        return r;
    endfunction

    function automatic logic [7:0] b_aff(input logic [7:0] x);
        logic [7:0] r;
        for (int i = 0; i < 8; i++)
            r[i] = x[i] ^ x[(i+4)%8] ^ x[(i+5)%8] ^ x[(i+6)%8] ^ x[(i+7)%8];
        return r ^ 8'h63;
    endfunction

    function automatic logic [31:0] rl(input logic [31:0] w, input int n);
        return (w << n) | (w >> (32 - n));
    endfunction

    function automatic logic [31:0] tau(input logic [31:0] a);
        return {sb[a[31:24]], sb[a[23:16]], sb[a[15:8]], sb[a[7:0]]};
    endfunction

    function automatic logic [127:0] ref_sm4(input logic [127:0] blk, input logic dec);
        logic [31:0] x [36];
        logic [31:0] b;
        for (int i = 0; i < 4; i++) x[i] = blk[127-32*i -: 32];
        for (int r = 0; r < 32; r++) begin
            b = tau(x[r+1] ^ x[r+2] ^ x[r+3] ^ (dec ? rk_mem[31-r] : rk_mem[r]));
            x[r+4] = x[r] ^ b ^ rl(b, 2) ^ rl(b, 10) ^ rl(b, 18) ^ rl(b, 24);
        end
        return {x[35], x[34], x[33], x[32]};
    endfunction

    task automatic build_tables();
        logic [7:0] p;
        logic [31:0] k [36];
        logic [31:0] ck;
        logic [31:0] fk [4];
        for (int v = 0; v < 256; v++) begin
            p = b_lin(8'(v), 8'h01, 8'h06, 8'h73, 8'hE5, 8'h56, 8'hA2, 8'h49, 8'h09, 8'h12);
            sb[v] = b_lin(b_aff(b_inv(p)), 8'h34,
                          8'h3C, 8'hA9, 8'hFA, 8'hB6, 8'hDC, 8'hAF, 8'hDD, 8'hBF);
        end
        fk[0] = 32'hA3B1BAC6; fk[1] = 32'h56AA3350;
        fk[2] = 32'h677D9197; fk[3] = 32'hB27022DC;
        for (int i = 0; i < 4; i++) k[i] = VEC_KEY[127-32*i -: 32] ^ fk[i];
        for (int i = 0; i < 32; i++) begin
            for (int j = 0; j < 4; j++) ck[31-8*j -: 8] = 8'(((4*i + j) * 7) % 256);
            p = 8'h00;
            k[i+4] = tau(k[i+1] ^ k[i+2] ^ k[i+3] ^ ck);
            k[i+4] = k[i] ^ k[i+4] ^ rl(k[i+4], 13) ^ rl(k[i+4], 23);
            rk_mem[i] = k[i+4];
        end
    endtask

    // ---------------- check helpers ----------------
    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    // ---------------- cycle model ----------------
    int           m_wait = 0;
    logic         m_done = 1'b0;
    logic         m_dec = 1'b0;
    logic [127:0] m_dout = '0;
    logic [127:0] m_pend = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wait <= 0; m_done <= 1'b0; m_dec <= 1'b0; m_dout <= '0;
        end else begin
            m_done <= 1'b0;
            if (m_wait == 0 && !m_done && start) begin
                m_wait <= 32;
                m_pend <= ref_sm4(din, decrypt);
                m_dec  <= decrypt;
            end else if (m_wait > 0) begin
                m_wait <= m_wait - 1;
                if (m_wait == 1) begin
                    m_done <= 1'b1;
                    m_dout <= m_pend;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            chk("R7 done per cycle", 128'(done), 128'(m_done));
            chk("R8 dout per cycle", dout, m_dout);
            if (m_wait > 0)
                chk("R3 key_idx per round", 128'(key_idx),
                    128'(m_dec ? (31 - (32 - m_wait)) : (32 - m_wait)));
        end
    end

    // ---------------- operations ----------------
    task automatic run_op(input logic [127:0] blk, input logic dec,
                          input int inj_at, input logic [127:0] inj_blk,
                          output logic [127:0] res, output int lat);
        @(negedge clk);
        start = 1'b1; din = blk; decrypt = dec;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            start = 1'b0;
            din = ~blk;
            decrypt = ~dec;
            if (inj_at != 0 && lat == inj_at) begin
                start = 1'b1; din = inj_blk;
            end
        end while (!done && lat < 100);
        start = 1'b0;
        res = dout;
    endtask

    initial begin
        logic [127:0] res, res2, held, blk;
        int lat;
        build_tables();
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 done in reset", 128'(done), 128'(0));
        chk("R1 dout in reset", dout, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", 128'(done), 128'(0));
        chk("R1 dout after reset", dout, '0);
        run_cmp = 1;

        // R4 / R5: published vector; R2 latency
        run_op(VEC_PT, 1'b0, 0, '0, res, lat);
        chk("R4 R5 vector ciphertext", res, VEC_CT);
        chk("R2 latency", 128'(lat), 128'(33));

        // R6: decrypt back
        run_op(VEC_CT, 1'b1, 0, '0, res, lat);
        chk("R6 vector decrypt", res, VEC_PT);
        chk("R2 latency decrypt", 128'(lat), 128'(33));

        // R9: start during rounds ignored
        blk = 128'h00112233445566778899AABBCCDDEEFF;
        run_op(blk, 1'b0, 7, ~blk, res, lat);
        chk("R9 busy start ignored result", res, ref_sm4(blk, 1'b0));
        chk("R9 busy start ignored latency", 128'(lat), 128'(33));

        // R9: start in the done cycle ignored; R8 hold
        held = dout;
        start = 1'b1; din = VEC_PT; decrypt = 1'b0;
        @(negedge clk);
        start = 1'b0;
        begin
            int seen = 0;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (done) seen++;
            end
            chk("R9 done-cycle start gives no done", 128'(seen), 128'(0));
        end
        chk("R8 dout held while idle", dout, held);

        // R4 / R6: corner and random blocks
        run_op('0, 1'b0, 0, '0, res, lat);
        chk("R4 all-zero block", res, ref_sm4('0, 1'b0));
        run_op('1, 1'b0, 0, '0, res, lat);
        chk("R4 all-ones block", res, ref_sm4('1, 1'b0));
        for (int n = 0; n < 6; n++) begin
            blk = {$urandom(), $urandom(), $urandom(), $urandom()};
            run_op(blk, 1'b0, 0, '0, res, lat);
            chk("R4 random encrypt", res, ref_sm4(blk, 1'b0));
            run_op(res, 1'b1, 0, '0, res2, lat);
            chk("R6 random round trip", res2, blk);
        end

        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

endmodule